// File: doc/BRIEF.md
# Isolated I/O Port Decoder with Byte-Lane Output Latches

This block sits on a processor's isolated I/O bus (a separate port address space with its own read and write strobes) and turns bus cycles into port actions. It watches a 16-bit port address, two byte-lane enables and the I/O read and write strobes. From these it produces write strobes that capture data into output latches, and it drives a read-data bus with a matching drive enable.

Three groups of ports are decoded. The first is a pair of 8-bit output ports at 40H and 41H. They sit in opposite byte lanes, and each lane is written only when its own byte enable is set, so software can update one byte or both at once. The second is a 16-bit output port at 64H/65H that always takes the full word. The third is an eight-address input window at EFF8H–EFFFH, served by an external input buffer through an active-low select.

Mapped ports read back their latched values, and reads ignore the byte enables. A read of any other address leaves the bus undriven. A parameter narrows decoding to address bits A7..A0, as a system that uses only fixed 8-bit port numbers would do.

Top module: `ioport_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released, `lat_even`, `lat_odd` and `lat_wide` are zero until they are written; with `io_rd` low, `rdata_oe` is 0 and `in_sel_n` is 1.
- R2: An `io_wr` cycle that matches the pair (address bits A15..A1 equal to 40H>>1) with `be_lo`=1 loads `wdata[7:0]` into `lat_even` at that clock edge; if `be_hi`=0, `lat_odd` keeps its value.
- R3: An `io_wr` cycle that matches the pair with `be_hi`=1 loads `wdata[15:8]` into `lat_odd`; if `be_lo`=0, `lat_even` keeps its value.
- R4: A pair write with both enables set updates both latches in the same edge, with `{lat_odd,lat_even}` = `wdata`.
- R5: An `io_wr` cycle at 64H or 65H loads all 16 bits of `wdata` into `lat_wide`, whatever the byte enables are (including both zero).
- R6: The latches hold their values in any cycle without a matching `io_wr`: `io_wr` low, an unmapped address, or an `io_rd` cycle.
- R7: An `io_rd` cycle at a mapped output port sets `rdata_oe`=1 and returns `{lat_odd,lat_even}` (40H/41H) or `lat_wide` (64H/65H) on `rdata` in the same cycle, whatever the byte enables are.
- R8: An `io_rd` cycle at an unmapped address, and any cycle with `io_rd` low, gives `rdata_oe`=0 and `rdata`=0.
- R9: `in_sel_n` is 0 only during an `io_rd` cycle whose address matches EFF8H in its upper 13 bits. In that cycle `rdata`=`ext_in` and `rdata_oe`=1.
- R10: With full decoding (`NARROW_DECODE`=0), an address that differs from a port only in A15..A8 (e.g. 0140H, 1064H) is unmapped.
- R11: With `NARROW_DECODE`=1, A15..A8 are ignored: 1240H acts as 40H, AB64H as 64H, and 00F9H falls in the input window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; latches capture on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Port address of the current bus cycle |
| be_lo | input | 1 | Low byte lane enable (even address, data bits 7..0) |
| be_hi | input | 1 | High byte lane enable (odd address, data bits 15..8) |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| wdata | input | 16 | Write data from the processor |
| ext_in | input | 16 | Data presented by the external input buffer |
| rdata | output | 16 | Read data toward the processor, zero when not driving |
| rdata_oe | output | 1 | Read data drive enable |
| in_sel_n | output | 1 | Active-low select for the external input buffer |
| lat_even | output | 8 | Output latch of port 40H |
| lat_odd | output | 8 | Output latch of port 41H |
| lat_wide | output | 16 | Output latch of the word port 64H/65H |

## Verification
The bench writes one byte lane at a time and checks that the other lane keeps its value. A design that strobed both latches from one shared write pulse would corrupt the neighbour port. It writes the word port with no byte enables set; a design that gated this port with the enables would miss the write. Reads are made with a single byte enable, or none, to expose a decoder that wrongly qualifies reads by lane. The bench also probes addresses next to each window (EFF7H, 66H) and aliases that differ only in A15..A8, so that an off-by-one range mask or a missing upper-byte compare shows up as a driven bus or an unwanted latch update. The narrow-decode build is checked to accept those same aliases.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
   localparam int LANE_W = 8;
   localparam int N_RD_SRC = 3;
   typedef enum int unsigned {
      SRC_PAIR = 0,
      SRC_WIDE = 1,
      SRC_WIN  = 2
   } rd_src_e;
endpackage

// File: rtl/iodec_match.sv
module iodec_match #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE = '0,
   parameter int LSB = 0,
   parameter bit NARROW = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int MSB = NARROW ? 7 : ADDR_W - 1;

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("iodec_match: ADDR_W must be at least 8");
      end
      if (LSB > MSB) begin : g_bad_lsb
         $error("iodec_match: LSB lies above the compared field");
      end
      if (NARROW) begin : g_narrow
         // only the fixed-port byte takes part in the compare
         assign hit = (addr[7:LSB] == BASE[7:LSB]);
      end else begin : g_full
         assign hit = (addr[ADDR_W-1:LSB] == BASE[ADDR_W-1:LSB]);
      end
   endgenerate

   logic unused_addr_bits;
   assign unused_addr_bits = ^addr;
endmodule

// File: rtl/iodec_latch.sv
module iodec_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("iodec_latch: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (en) q <= d;
   end

   // R6: without a strobe the stored value is kept
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q));
   // R2: a strobe captures the bus value of that cycle
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (q == $past(d)));
endmodule

// File: rtl/iodec_rdmux.sv
module iodec_rdmux #(
   parameter int DATA_W = 16,
   parameter int N = 3
) (
   input  logic [N-1:0]             sel,
   input  logic [N-1:0][DATA_W-1:0] src,
   output logic [DATA_W-1:0]        data,
   output logic                     oe
);
   generate
      if (N < 1) begin : g_bad_n
         $error("iodec_rdmux: N must be positive");
      end
   endgenerate

   always_comb begin
      data = '0;
      for (int i = 0; i < N; i++) begin
         if (sel[i]) data = data | src[i];
      end
   end

   assign oe = |sel;
endmodule

// File: rtl/ioport_decoder.sv
module ioport_decoder
   import iodec_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter bit NARROW_DECODE = 1'b0,
   parameter logic [ADDR_W-1:0] PAIR_BASE = 16'h0040,
   parameter logic [ADDR_W-1:0] WIDE_BASE = 16'h0064,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hEFF8,
   parameter int WIN_KEEP = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              be_lo,
   input  logic              be_hi,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              in_sel_n,
   output logic [LANE_W-1:0] lat_even,
   output logic [LANE_W-1:0] lat_odd,
   output logic [DATA_W-1:0] lat_wide
);
   localparam int N_LANES = DATA_W / LANE_W;
   localparam int WIN_LSB = ADDR_W - WIN_KEEP;
   localparam int PAIR_LSB = $clog2(N_LANES);

   generate
      if (DATA_W != 2 * LANE_W) begin : g_bad_data
         $error("ioport_decoder: the data bus must be two byte lanes");
      end
      if (PAIR_BASE[0] != 1'b0 || WIDE_BASE[0] != 1'b0) begin : g_bad_align
         $error("ioport_decoder: port bases must be even");
      end
      if (WIN_KEEP < 1 || WIN_KEEP > ADDR_W) begin : g_bad_keep
         $error("ioport_decoder: WIN_KEEP out of range");
      end
   endgenerate

   logic pair_dec, wide_dec, win_dec;

   iodec_match #(.ADDR_W(ADDR_W), .BASE(PAIR_BASE), .LSB(PAIR_LSB),
                 .NARROW(NARROW_DECODE)) u_pair_match (.addr(addr), .hit(pair_dec));
   iodec_match #(.ADDR_W(ADDR_W), .BASE(WIDE_BASE), .LSB(PAIR_LSB),
                 .NARROW(NARROW_DECODE)) u_wide_match (.addr(addr), .hit(wide_dec));
   iodec_match #(.ADDR_W(ADDR_W), .BASE(WIN_BASE), .LSB(WIN_LSB),
                 .NARROW(NARROW_DECODE)) u_win_match (.addr(addr), .hit(win_dec));

   // per-lane write strobes: each byte bank gets its own qualified pulse
   logic [N_LANES-1:0] lane_be;
   logic [N_LANES-1:0] lane_wr;
   logic [N_LANES-1:0][LANE_W-1:0] lane_q;
   assign lane_be = {be_hi, be_lo};

   genvar gi;
   generate
      for (gi = 0; gi < N_LANES; gi++) begin : g_lane
         assign lane_wr[gi] = io_wr & pair_dec & lane_be[gi];
         iodec_latch #(.W(LANE_W)) u_lat (
            .clk(clk), .rst_n(rst_n), .en(lane_wr[gi]),
            .d(wdata[gi*LANE_W +: LANE_W]), .q(lane_q[gi]));
      end
   endgenerate

   assign lat_even = lane_q[0];
   assign lat_odd  = lane_q[1];

   // word port: lane enables play no part
   logic wide_wr;
   assign wide_wr = io_wr & wide_dec;
   iodec_latch #(.W(DATA_W)) u_wide_lat (
      .clk(clk), .rst_n(rst_n), .en(wide_wr), .d(wdata), .q(lat_wide));

   // read side: lane enables ignored, whole word presented
   logic [N_RD_SRC-1:0] rd_sel;
   logic [N_RD_SRC-1:0][DATA_W-1:0] rd_src;
   always_comb begin
      rd_sel = '0;
      rd_sel[SRC_PAIR] = io_rd & pair_dec;
      rd_sel[SRC_WIDE] = io_rd & wide_dec;
      rd_sel[SRC_WIN]  = io_rd & win_dec;
      rd_src = '0;
      rd_src[SRC_PAIR] = {lane_q[1], lane_q[0]};
      rd_src[SRC_WIDE] = lat_wide;
      rd_src[SRC_WIN]  = ext_in;
   end

   iodec_rdmux #(.DATA_W(DATA_W), .N(N_RD_SRC)) u_rdmux (
      .sel(rd_sel), .src(rd_src), .data(rdata), .oe(rdata_oe));

   assign in_sel_n = ~rd_sel[SRC_WIN];

   // R2: low-lane-only write leaves the odd port alone
   p_lane_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && pair_dec && be_lo && !be_hi) |=> $stable(lat_odd));
   // R3: high-lane-only write leaves the even port alone
   p_lane_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && pair_dec && be_hi && !be_lo) |=> ($stable(lat_even) && lat_odd == $past(wdata[15:8])));
   // R4: full-word pair write lands in both banks together
   p_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && pair_dec && be_lo && be_hi) |=> ({lat_odd, lat_even} == $past(wdata)));
   // R5: word port loads regardless of lane enables
   p_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && wide_dec) |=> (lat_wide == $past(wdata)));
   // R7: at most one read source at a time
   p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_sel));
   // R8: bus is driven only inside a read strobe
   p_oe_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> io_rd);
   // R8: undriven bus carries zero
   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == '0));
   // R9: buffer select implies the buffer data is on the bus
   p_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_sel_n |-> (rdata_oe && rdata == ext_in));
endmodule

// File: tb/sim_ioport_decoder.sv
module sim_ioport_decoder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic be_lo = 1'b0, be_hi = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
   logic [15:0] wdata = '0, ext_in = '0;

   logic [15:0] rdata0, rdata1, lat_wide0, lat_wide1;
   logic rdata_oe0, rdata_oe1, in_sel_n0, in_sel_n1;
   logic [7:0] lat_even0, lat_odd0, lat_even1, lat_odd1;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   ioport_decoder u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .be_lo(be_lo), .be_hi(be_hi),
      .io_rd(io_rd), .io_wr(io_wr), .wdata(wdata), .ext_in(ext_in),
      .rdata(rdata0), .rdata_oe(rdata_oe0), .in_sel_n(in_sel_n0),
      .lat_even(lat_even0), .lat_odd(lat_odd0), .lat_wide(lat_wide0));

   ioport_decoder #(.NARROW_DECODE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .be_lo(be_lo), .be_hi(be_hi),
      .io_rd(io_rd), .io_wr(io_wr), .wdata(wdata), .ext_in(ext_in),
      .rdata(rdata1), .rdata_oe(rdata_oe1), .in_sel_n(in_sel_n1),
      .lat_even(lat_even1), .lat_odd(lat_odd1), .lat_wide(lat_wide1));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic lo, input logic hi,
                            input logic [15:0] d);
      @(negedge clk);
      addr = a; be_lo = lo; be_hi = hi; wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; be_lo = 1'b0; be_hi = 1'b0;
   endtask

   task automatic bus_read_start(input logic [15:0] a, input logic lo, input logic hi);
      @(negedge clk);
      addr = a; be_lo = lo; be_hi = hi; io_rd = 1'b1;
      #1;
   endtask

   task automatic bus_read_end();
      io_rd = 1'b0; be_lo = 1'b0; be_hi = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 even", lat_even0, 8'h00);
      chk("R1 odd", lat_odd0, 8'h00);
      chk("R1 wide", lat_wide0, 16'h0000);
      chk("R1 oe", rdata_oe0, 1'b0);
      chk("R1 sel_n", in_sel_n0, 1'b1);
   endtask

   task automatic t_byte_lo();
      bus_write(16'h0040, 1'b1, 1'b0, 16'hA5C3);
      chk("R2 even", lat_even0, 8'hC3);
      chk("R2 odd kept", lat_odd0, 8'h00);
   endtask

   task automatic t_byte_hi();
      bus_write(16'h0041, 1'b0, 1'b1, 16'h7E11);
      chk("R3 odd", lat_odd0, 8'h7E);
      chk("R3 even kept", lat_even0, 8'hC3);
   endtask

   task automatic t_word();
      bus_write(16'h0040, 1'b1, 1'b1, 16'h1234);
      chk("R4 pair word", {lat_odd0, lat_even0}, 16'h1234);
   endtask

   task automatic t_wide();
      bus_write(16'h0065, 1'b0, 1'b0, 16'hBEEF);
      chk("R5 wide no enables", lat_wide0, 16'hBEEF);
      bus_write(16'h0064, 1'b1, 1'b0, 16'hCAFE);
      chk("R5 wide low enable", lat_wide0, 16'hCAFE);
   endtask

   task automatic t_hold();
      @(negedge clk);
      addr = 16'h0040; be_lo = 1'b1; be_hi = 1'b1; wdata = 16'hFFFF;
      @(negedge clk);
      chk("R6 no strobe", {lat_odd0, lat_even0}, 16'h1234);
      bus_write(16'h0042, 1'b1, 1'b1, 16'hFFFF);
      chk("R6 unmapped write", {lat_odd0, lat_even0}, 16'h1234);
      chk("R6 unmapped write wide", lat_wide0, 16'hCAFE);
      bus_read_start(16'h0040, 1'b1, 1'b1);
      @(negedge clk);
      bus_read_end();
      chk("R6 read leaves latch", {lat_odd0, lat_even0}, 16'h1234);
   endtask

   task automatic t_read();
      bus_read_start(16'h0040, 1'b0, 1'b1);
      chk("R7 pair oe", rdata_oe0, 1'b1);
      chk("R7 pair data", rdata0, 16'h1234);
      bus_read_end();
      bus_read_start(16'h0041, 1'b0, 1'b0);
      chk("R7 odd addr data", rdata0, 16'h1234);
      bus_read_end();
      bus_read_start(16'h0064, 1'b1, 1'b0);
      chk("R7 wide data", rdata0, 16'hCAFE);
      chk("R7 wide sel_n", in_sel_n0, 1'b1);
      bus_read_end();
   endtask

   task automatic t_unmapped();
      bus_read_start(16'h0066, 1'b1, 1'b1);
      chk("R8 oe", rdata_oe0, 1'b0);
      chk("R8 data", rdata0, 16'h0000);
      bus_read_end();
      #1;
      chk("R8 idle oe", rdata_oe0, 1'b0);
   endtask

   task automatic t_window();
      ext_in = 16'h5A5A;
      bus_read_start(16'hEFF8, 1'b1, 1'b1);
      chk("R9 sel_n low", in_sel_n0, 1'b0);
      chk("R9 data", rdata0, 16'h5A5A);
      chk("R9 oe", rdata_oe0, 1'b1);
      bus_read_end();
      ext_in = 16'h0F3C;
      bus_read_start(16'hEFFF, 1'b0, 1'b1);
      chk("R9 top data", rdata0, 16'h0F3C);
      bus_read_end();
      bus_read_start(16'hEFF7, 1'b1, 1'b1);
      chk("R9 below sel_n", in_sel_n0, 1'b1);
      chk("R9 below oe", rdata_oe0, 1'b0);
      bus_read_end();
      @(negedge clk);
      addr = 16'hEFFA;
      #1;
      chk("R9 no strobe sel_n", in_sel_n0, 1'b1);
   endtask

   task automatic t_full_decode();
      bus_write(16'h0140, 1'b1, 1'b1, 16'h9999);
      chk("R10 alias write", {lat_odd0, lat_even0}, 16'h1234);
      bus_read_start(16'h1064, 1'b1, 1'b1);
      chk("R10 alias read oe", rdata_oe0, 1'b0);
      bus_read_end();
   endtask

   task automatic t_narrow();
      bus_write(16'h1240, 1'b1, 1'b1, 16'h4321);
      chk("R11 narrow pair", {lat_odd1, lat_even1}, 16'h4321);
      bus_read_start(16'hAB64, 1'b0, 1'b0);
      chk("R11 narrow wide oe", rdata_oe1, 1'b1);
      chk("R11 narrow wide data", rdata1, 16'hCAFE);
      bus_read_end();
      ext_in = 16'h8181;
      bus_read_start(16'h00F9, 1'b1, 1'b0);
      chk("R11 narrow window sel_n", in_sel_n1, 1'b0);
      chk("R11 narrow window data", rdata1, 16'h8181);
      bus_read_end();
      bus_read_start(16'h1066, 1'b1, 1'b1);
      chk("R11 narrow unmapped", rdata_oe1, 1'b0);
      bus_read_end();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte_lo();
      t_byte_hi();
      t_word();
      t_wide();
      t_hold();
      t_read();
      t_unmapped();
      t_window();
      t_full_decode();
      t_narrow();
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule